// File: doc/BRIEF.md
# Serial Register-Access Target with Burst Addressing

This block lets an external host read and write a bank of byte-wide registers over a four-wire serial link. The host drives a clock, a data-in line and an active-low select. The block returns read data on a single data-out line. Every transaction starts when select goes low. The first byte carries the command: a transfer direction, an address-step flag and a register address. Any number of data bytes may follow, and each one is stored into the register bank or fetched from it.

The serial lines come into the chip's own clock domain through synchronizers, and the block detects the edges of the serial clock itself. Because of this, the serial clock must run well below the system clock. An event input sets a sticky interrupt flag, which drives an active-high interrupt output to the host. The host clears the flag by writing a 1 to bit 0 of a dedicated status address. That status address is not part of the storage bank.

Top module: `spiRegTarget`

## Requirements
- R1: Command byte fields: bit 7 = 1 selects write and 0 selects read, bit 6 = 1 enables address stepping, and bits 5:0 give the start address. Bytes travel MSB first in mode 0: data-in is sampled on the rising serial-clock edge and data-out changes on the falling edge.
- R2: In a write transaction, each data byte is stored in the register at the current address, unless that address is the status address.
- R3: In a read transaction, data-out shows the MSB of the addressed register before the first rising edge of each data byte, and the remaining bits follow MSB first.
- R4: With the step flag at 1, the current address advances by one after every data byte and wraps from 63 to 0.
- R5: With the step flag at 0, every data byte in the burst uses the start address.
- R6: Raising select at any point ends the transaction and discards any partial byte. The next byte after select falls again is decoded as a command. Serial-clock edges while select is high change nothing.
- R7: Data-out is held low while select is high and after reset. The interrupt output is low after reset.
- R8: A one-cycle pulse on the event input sets the interrupt output, and it stays high until it is cleared.
- R9: A read of the status address (32) returns the interrupt flag in bit 0 and zeros elsewhere. A written byte with bit 0 = 1 clears the flag. A written byte with bit 0 = 0 leaves it unchanged.
- R10: All storage registers read as zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| ssN | input | 1 | Active-low transaction select |
| eventIn | input | 1 | Interrupt event pulse, synchronous to clk |
| miso | output | 1 | Serial data to the host, low when idle |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with its default values: a 6-bit address, byte-wide data, status at address 32 and two synchronizer stages. With these values a stepped burst that starts at 62 crosses the 63-to-0 wrap and lands on real storage, and no stepped burst in the test runs through the status slot. The serial clock runs at one sixteenth of the system clock. This leaves room for the synchronizer delay, so the bench can observe the first read bit appearing before the first data-byte rising edge. With two stages the bench can also end a transaction after only a few bits, both inside the command byte and inside a data byte.

// File: rtl/spiRegPkg.sv
package spiRegPkg;
  // Strobes issued by the control path to the datapath each clk cycle
  typedef struct packed {
    logic sampleBit;  // capture one data-in bit
    logic shiftOut;   // present the next data-out bit
    logic wrEn;       // store the completed byte
    logic loadTx;     // prefetch a register into the transmit shifter
    logic clearAll;   // select is high: drop partial state
  } spiStrobes_t;
endpackage

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiRegPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ssActive,
  input  logic              sckRise,
  input  logic              sckFall,
  input  logic [DATA_W-1:0] rxNext,
  output spiStrobes_t       strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam int DIR_BIT = DATA_W - 1;
  localparam int INC_BIT = DATA_W - 2;

  logic [CNT_W-1:0]  bitCnt;
  logic              inData;
  logic              isWrite;
  logic              isInc;
  logic [ADDR_W-1:0] curAddr;
  logic              lastBit;
  logic              byteDone;
  logic [ADDR_W-1:0] stepAddr;

  assign lastBit  = (bitCnt == CNT_W'(DATA_W - 1));
  assign byteDone = sckRise && lastBit;
  assign stepAddr = isInc ? curAddr + ADDR_W'(1) : curAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      inData  <= 1'b0;
      isWrite <= 1'b0;
      isInc   <= 1'b0;
      curAddr <= '0;
    end else if (!ssActive) begin
      bitCnt <= '0;
      inData <= 1'b0;
    end else if (sckRise) begin
      bitCnt <= lastBit ? '0 : bitCnt + CNT_W'(1);
      if (lastBit) begin
        if (!inData) begin
          inData  <= 1'b1;
          isWrite <= rxNext[DIR_BIT];
          isInc   <= rxNext[INC_BIT];
          curAddr <= rxNext[ADDR_W-1:0];
        end else begin
          curAddr <= stepAddr;
        end
      end
    end
  end

  always_comb begin
    strobes.sampleBit = sckRise;
    strobes.shiftOut  = sckFall;
    strobes.wrEn      = byteDone && inData && isWrite;
    strobes.loadTx    = byteDone && (inData ? !isWrite : !rxNext[DIR_BIT]);
    strobes.clearAll  = !ssActive;
    wrAddr            = curAddr;
    rdAddr            = inData ? stepAddr : rxNext[ADDR_W-1:0];
  end

  // R4: stepping past the top address returns to zero
  p_addr_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && inData && isInc && curAddr == '1) |=> (curAddr == '0));

  // R5: with stepping off the address never moves inside a burst
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && inData && !isInc) |=> $stable(curAddr));

  // R6: an idle select leaves no partial bit count behind
  p_bitcnt_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ssActive |=> (bitCnt == '0 && !inData));
endmodule

// File: rtl/spiRegDatapath.sv
module spiRegDatapath
  import spiRegPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int STATUS_ADDR = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobes_t       strobes,
  input  logic              mosiBit,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              eventIn,
  output logic [DATA_W-1:0] rxNext,
  output logic              misoBit,
  output logic              irq
);
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] STAT = ADDR_W'(STATUS_ADDR);

  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] regBank [NUM_REGS];
  logic [DATA_W-1:0] rdData;
  logic              misoReg;
  logic              irqFlag;
  logic              statusClr;

  assign rxNext    = {rxShift[DATA_W-2:0], mosiBit};
  assign statusClr = strobes.wrEn && (wrAddr == STAT) && rxNext[0];
  assign rdData    = (rdAddr == STAT) ? {{(DATA_W-1){1'b0}}, irqFlag}
                                      : regBank[rdAddr];
  assign misoBit   = misoReg;
  assign irq       = irqFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rxShift <= '0;
    else if (strobes.clearAll) rxShift <= '0;
    else if (strobes.sampleBit) rxShift <= rxNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regBank[i] <= '0;
    end else if (strobes.wrEn && wrAddr != STAT) begin
      regBank[wrAddr] <= rxNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      misoReg <= 1'b0;
    end else if (strobes.clearAll) begin
      txShift <= '0;
      misoReg <= 1'b0;
    end else if (strobes.loadTx) begin
      txShift <= rdData;
    end else if (strobes.shiftOut) begin
      misoReg <= txShift[DATA_W-1];
      txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          irqFlag <= 1'b0;
    else if (eventIn)   irqFlag <= 1'b1;
    else if (statusClr) irqFlag <= 1'b0;
  end

  // R2: a completed write byte lands in the addressed register
  p_write_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEn && wrAddr != STAT) |=> (regBank[$past(wrAddr)] == $past(rxNext)));

  // R8: an event always leaves the flag set
  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    eventIn |=> irq);

  // R8: without a clearing write the flag is sticky
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(strobes.wrEn && wrAddr == STAT)) |=> irq);

  // R9: a clearing write with no event drops the flag
  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEn && wrAddr == STAT && rxNext[0] && !eventIn) |=> !irq);
endmodule

// File: rtl/spiRegTarget.sv
module spiRegTarget
  import spiRegPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int STATUS_ADDR = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sck,
  input  logic mosi,
  input  logic ssN,
  input  logic eventIn,
  output logic miso,
  output logic irq
);
  logic [SYNC_STAGES-1:0] sckPipe;
  logic [SYNC_STAGES-1:0] mosiPipe;
  logic [SYNC_STAGES-1:0] ssPipe;
  logic                   sckPrev;
  logic                   sckS;
  logic                   mosiS;
  logic                   ssActive;
  logic                   sckRise;
  logic                   sckFall;

  spiStrobes_t       strobes;
  logic [DATA_W-1:0] rxNext;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckPipe <= '0; mosiPipe <= '0; ssPipe <= '1;
        end else begin
          sckPipe <= sck; mosiPipe <= mosi; ssPipe <= ssN;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckPipe <= '0; mosiPipe <= '0; ssPipe <= '1;
        end else begin
          sckPipe  <= {sckPipe[SYNC_STAGES-2:0], sck};
          mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
          ssPipe   <= {ssPipe[SYNC_STAGES-2:0], ssN};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckS;
  end

  assign sckS     = sckPipe[SYNC_STAGES-1];
  assign mosiS    = mosiPipe[SYNC_STAGES-1];
  assign ssActive = !ssPipe[SYNC_STAGES-1];
  assign sckRise  = ssActive && sckS && !sckPrev;
  assign sckFall  = ssActive && !sckS && sckPrev;

  spiRegCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .ssActive(ssActive), .sckRise(sckRise),
    .sckFall(sckFall), .rxNext(rxNext), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  spiRegDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .mosiBit(mosiS),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .eventIn(eventIn),
    .rxNext(rxNext), .misoBit(miso), .irq(irq)
  );

  // R7: data-out drops low once select is seen high
  p_miso_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ssActive |=> !miso);
endmodule

// File: tb/spiRegTarget_tb_top.sv
module spiRegTarget_tb_top;
  localparam int HALF = 32; // ns, serial half period = 8 system clocks

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic ssN = 1'b1;
  logic eventIn = 1'b0;
  logic miso;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] txBuf [16];
  logic [7:0] rxBuf [16];

  // {address, value} pairs for single write then single read
  localparam logic [13:0] VEC_TABLE [8] = '{
    {6'd1, 8'hA5}, {6'd5, 8'h3C}, {6'd17, 8'hFF}, {6'd31, 8'h01},
    {6'd40, 8'h80}, {6'd63, 8'h7E}, {6'd62, 8'h96}, {6'd7, 8'h5A}
  };

  always #2 clk = ~clk;

  spiRegTarget dut_i (
    .clk(clk), .rstN(rstN), .sck(sck), .mosi(mosi), .ssN(ssN),
    .eventIn(eventIn), .miso(miso), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic shiftByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      #HALF sck = 1'b1;
      rx[i] = miso;
      #HALF sck = 1'b0;
    end
  endtask

  task automatic xfer(input int n);
    ssN = 1'b0;
    #HALF;
    for (int k = 0; k < n; k++) shiftByte(txBuf[k], rxBuf[k]);
    #HALF ssN = 1'b1;
    #(2 * HALF);
  endtask

  task automatic partialXfer(input logic [7:0] cmd, input int extraBits, input bit sendCmd);
    logic [7:0] dummy;
    ssN = 1'b0;
    #HALF;
    if (sendCmd) shiftByte(cmd, dummy);
    for (int i = 0; i < extraBits; i++) begin
      mosi = 1'b1;
      #HALF sck = 1'b1;
      #HALF sck = 1'b0;
    end
    #HALF ssN = 1'b1;
    #(2 * HALF);
  endtask

  task automatic writeReg(input logic [5:0] a, input logic [7:0] d);
    txBuf[0] = {2'b10, a};
    txBuf[1] = d;
    xfer(2);
  endtask

  task automatic readReg(input logic [5:0] a, output logic [7:0] d);
    txBuf[0] = {2'b00, a};
    txBuf[1] = 8'h00;
    xfer(2);
    d = rxBuf[1];
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    logic [7:0] rd;
    #1;
    #20 rstN = 1'b1;
    #20;
    // R7 reset state of outputs
    check("R7 miso after reset", miso, 0);
    check("R7 irq after reset", irq, 0);
    // R10 storage cleared by reset
    readReg(6'd5, rd);
    check("R10 reg5 after reset", rd, 0);
    readReg(6'd32, rd);
    check("R9 status after reset", rd, 0);

    // R1 R2 R3 table of single writes and reads
    foreach (VEC_TABLE[v]) begin
      writeReg(VEC_TABLE[v][13:8], VEC_TABLE[v][7:0]);
      readReg(VEC_TABLE[v][13:8], rd);
      check("R1 R2 R3 vector readback", rd, VEC_TABLE[v][7:0]);
    end

    // R4 stepped write burst across the wrap, then stepped read burst
    txBuf[0] = 8'hFE; txBuf[1] = 8'h11; txBuf[2] = 8'h22;
    txBuf[3] = 8'h33; txBuf[4] = 8'h44;
    xfer(5);
    txBuf[0] = 8'h7E;
    for (int k = 1; k < 5; k++) txBuf[k] = 8'h00;
    xfer(5);
    check("R4 burst addr 62", rxBuf[1], 8'h11);
    check("R4 burst addr 63", rxBuf[2], 8'h22);
    check("R4 burst wrap addr 0", rxBuf[3], 8'h33);
    check("R4 burst addr 1", rxBuf[4], 8'h44);

    // R5 fixed-address burst
    txBuf[0] = 8'h8A; txBuf[1] = 8'h5A; txBuf[2] = 8'h6B; txBuf[3] = 8'h7C;
    xfer(4);
    readReg(6'd10, rd);
    check("R5 last byte wins at addr 10", rd, 8'h7C);
    readReg(6'd11, rd);
    check("R5 neighbour addr 11 untouched", rd, 8'h00);
    txBuf[0] = 8'h0A; txBuf[1] = 8'h00; txBuf[2] = 8'h00; txBuf[3] = 8'h00;
    xfer(4);
    check("R5 fixed read byte 1", rxBuf[1], 8'h7C);
    check("R5 fixed read byte 3", rxBuf[3], 8'h7C);

    // R6 abort inside a data byte and inside a command byte
    writeReg(6'd20, 8'h3C);
    partialXfer(8'h94, 4, 1'b1);
    readReg(6'd20, rd);
    check("R6 partial data byte discarded", rd, 8'h3C);
    partialXfer(8'h00, 3, 1'b0);
    readReg(6'd20, rd);
    check("R6 next byte decoded as command", rd, 8'h3C);
    // R6 R7 serial clock activity with select high
    for (int i = 0; i < 16; i++) begin
      mosi = 1'b1;
      #HALF sck = 1'b1;
      #HALF sck = 1'b0;
    end
    #(2 * HALF);
    check("R7 miso low while deselected", miso, 0);
    readReg(6'd20, rd);
    check("R6 clocks while deselected ignored", rd, 8'h3C);

    // R8 R9 interrupt flag
    @(negedge clk) eventIn = 1'b1;
    @(negedge clk) eventIn = 1'b0;
    @(negedge clk);
    check("R8 irq set by event", irq, 1);
    readReg(6'd32, rd);
    check("R9 status shows flag", rd, 8'h01);
    check("R8 irq sticky across read", irq, 1);
    writeReg(6'd32, 8'hFE);
    check("R9 write with bit0 clear keeps flag", irq, 1);
    writeReg(6'd32, 8'h01);
    check("R9 write 1 clears flag", irq, 0);
    readReg(6'd32, rd);
    check("R9 status after clear", rd, 8'h00);
    readReg(6'd62, rd);
    check("R2 status write leaves storage", rd, 8'h11);

    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end
endmodule